// File: doc/BRIEF.md
# Scatter-Gather Receive Request Channel

This block is one channel of a host-to-device receive path. Software programs a small set of channel registers: the number of 32-bit words to move, a last-transfer flag, the 64-bit address of a scatter-gather list held in host memory, and the size of that list in words. Writing the list size starts the channel. The channel first issues a single read request for the list. The words that come back are grouped into elements of four words, and each element is a buffer address plus a buffer length. These elements are queued in a small FIFO.

The channel then takes elements from the FIFO in order and expands each one into a series of data read requests. Each request is bounded in size and never crosses a page edge. Completion words are assumed to arrive in request order, one per cycle. They are forwarded to an output word stream and counted against the programmed transfer length. When the final word goes out, the channel raises its interrupt in the same cycle and sets its own bit in a status register. Software reads that register to learn which channel finished, and the read also clears the bit.

Top module: `sg_rx_channel`

## Requirements
- R1: While idle, a write of a nonzero value to the list-size register (offset 4), with a nonzero transfer length already held (offset 0), issues exactly one request with `req_is_list`=1, address {offset 3, offset 2} and length equal to the written list size.
- R2: List completion words are taken four at a time in this order: buffer address bits 31:0, buffer address bits 63:32, buffer length in words, then an unused word.
- R3: Every data request carries a length of at least 1 and at most MAX_REQ_WORDS (32) words.
- R4: No data request spans a PAGE_BYTES (4096) address boundary: address bits 11:0 plus four times the length is at most 4096.
- R5: Elements are served in list order. Each element is covered by contiguous requests, each starting where the previous one ended, and an element of length zero yields no request.
- R6: Each data completion word appears on `out_data` with `out_valid` one cycle after it is presented, in arrival order.
- R7: The channel completes when the received word count equals the transfer length. Requests never ask for more words in total than that length, and any elements still queued are dropped.
- R8: `out_last` is high together with the final word only when bit 0 of the offset/last register (offset 1) was written as 1. It is low on all other words.
- R9: `irq` rises in the same cycle as the final output word, and `stat_rd_data` bit CHAN_ID is then 1.
- R10: A cycle with `stat_rd_en` high clears the status bits, so `irq` and `stat_rd_data` are 0 in the following cycle unless a new completion lands in that same cycle.
- R11: Register writes made while the channel is busy are ignored. They neither start a transfer nor change the held length.
- R12: A request held without `req_ready` keeps its address and length unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register offset: 0 length, 1 offset/last, 2 list address low, 3 list address high, 4 list size |
| reg_wr_data | input | 32 | Register write data |
| stat_rd_en | input | 1 | Status register read strobe (clears on read) |
| stat_rd_data | output | NUM_CH | Per-channel done bits |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_is_list | output | 1 | Request is for the scatter-gather list |
| req_addr | output | 64 | Request byte address |
| req_len | output | 32 | Request length in 32-bit words |
| cpl_valid | input | 1 | Completion word valid |
| cpl_data | input | 32 | Completion word |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word |
| out_last | output | 1 | Final word of a transfer flagged last |
| irq | output | 1 | Interrupt, OR of the status bits |

## Verification
The bench targets an element that starts 64 bytes below a page edge. A splitter that ignored the edge would issue a single 32-word request across the boundary instead of 16 then 24 words. A zero-length element placed between two others checks that an empty buffer is skipped and not requested. A design that did not skip it would stall or emit a zero-length request. A transfer length shorter than the first element must end the channel after exactly that many words. A design that trusted element lengths would keep requesting and never raise the interrupt at the right word. Register writes made while the channel is busy are followed by a restart that relies on the originally held length, so a design that accepted those writes would deliver the wrong word count. Random request stalls expose a request that drifts while it waits.

// File: rtl/sg_rx_pkg.sv
`timescale 1ns/1ps
package sg_rx_pkg;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] len;
    } sg_elem_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LIST_REQ,
        ST_LIST_RX,
        ST_DATA
    } ch_state_e;

    localparam logic [2:0] RA_XFER_LEN = 3'd0;
    localparam logic [2:0] RA_OFF_LAST = 3'd1;
    localparam logic [2:0] RA_LIST_LO  = 3'd2;
    localparam logic [2:0] RA_LIST_HI  = 3'd3;
    localparam logic [2:0] RA_LIST_LEN = 3'd4;

endpackage

// File: rtl/sg_elem_fifo.sv
`timescale 1ns/1ps
module sg_elem_fifo
    import sg_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  logic     push,
    input  sg_elem_t din,
    input  logic     pop,
    output sg_elem_t dout,
    output logic     empty,
    output logic     full
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t     p_d, p_q;
    sg_elem_t mem [DEPTH];
    logic     do_push, do_pop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (p_q.cnt == '0);
    assign full    = (p_q.cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[p_q.rd];

    always_comb begin
        p_d = p_q;
        if (clr) begin
            p_d = '0;
        end else begin
            if (do_push) p_d.wr = nxt(p_q.wr);
            if (do_pop)  p_d.rd = nxt(p_q.rd);
            case ({do_push, do_pop})
                2'b10:   p_d.cnt = p_q.cnt + 1'b1;
                2'b01:   p_d.cnt = p_q.cnt - 1'b1;
                default: p_d.cnt = p_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[p_q.wr] <= din;
    end
endmodule

// File: rtl/sg_req_split.sv
`timescale 1ns/1ps
module sg_req_split #(
    parameter int unsigned MAX_REQ_WORDS = 32,
    parameter int unsigned PAGE_BYTES    = 4096,
    localparam int unsigned PG_W         = $clog2(PAGE_BYTES)
) (
    input  logic [PG_W-1:0] page_off,
    input  logic [31:0]     elem_rem,
    input  logic [31:0]     xfer_rem,
    output logic [31:0]     chunk
);
    logic [PG_W:0] edge_bytes;
    logic [31:0]   edge_words;
    logic [31:0]   m0, m1;

    always_comb begin
        edge_bytes = (PG_W+1)'(PAGE_BYTES) - {1'b0, page_off};
        edge_words = 32'(edge_bytes >> 2);
        m0    = (elem_rem < xfer_rem) ? elem_rem : xfer_rem;
        m1    = (m0 < edge_words) ? m0 : edge_words;
        chunk = (m1 < 32'(MAX_REQ_WORDS)) ? m1 : 32'(MAX_REQ_WORDS);
    end
endmodule

// File: rtl/sg_rx_channel.sv
`timescale 1ns/1ps
module sg_rx_channel
    import sg_rx_pkg::*;
#(
    parameter int unsigned MAX_REQ_WORDS = 32,
    parameter int unsigned PAGE_BYTES    = 4096,
    parameter int unsigned FIFO_DEPTH    = 4,
    parameter int unsigned NUM_CH        = 4,
    parameter int unsigned CHAN_ID       = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_wr_addr,
    input  logic [31:0]       reg_wr_data,
    input  logic              stat_rd_en,
    output logic [NUM_CH-1:0] stat_rd_data,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_is_list,
    output logic [63:0]       req_addr,
    output logic [31:0]       req_len,
    input  logic              cpl_valid,
    input  logic [31:0]       cpl_data,
    output logic              out_valid,
    output logic [31:0]       out_data,
    output logic              out_last,
    output logic              irq
);
    localparam int unsigned PG_W = $clog2(PAGE_BYTES);

    typedef struct packed {
        ch_state_e         state;
        logic [31:0]       xfer_len;
        logic              last_flag;
        logic [63:0]       list_addr;
        logic [31:0]       list_len;
        logic [31:0]       list_cnt;
        logic [63:0]       asm_addr;
        logic [31:0]       asm_len;
        logic [63:0]       cur_addr;
        logic [31:0]       cur_rem;
        logic              cur_valid;
        logic [31:0]       req_total;
        logic [31:0]       rx_cnt;
        logic              out_valid;
        logic [31:0]       out_data;
        logic              out_last;
        logic [NUM_CH-1:0] done;
    } ch_regs_t;

    ch_regs_t  s_d, s_q;
    sg_elem_t  fifo_din, fifo_dout;
    logic      fifo_push, fifo_pop, fifo_clr, fifo_empty, fifo_full;
    logic [31:0] chunk;
    logic      more;

    sg_elem_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fifo_clr),
        .push  (fifo_push),
        .din   (fifo_din),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    sg_req_split #(.MAX_REQ_WORDS(MAX_REQ_WORDS), .PAGE_BYTES(PAGE_BYTES)) u_split (
        .page_off (s_q.cur_addr[PG_W-1:0]),
        .elem_rem (s_q.cur_rem),
        .xfer_rem (s_q.xfer_len - s_q.req_total),
        .chunk    (chunk)
    );

    assign fifo_din = '{addr: s_q.asm_addr, len: s_q.asm_len};
    assign more     = s_q.req_total < s_q.xfer_len;

    always_comb begin
        s_d         = s_q;
        s_d.out_valid = 1'b0;
        s_d.out_last  = 1'b0;
        fifo_push   = 1'b0;
        fifo_pop    = 1'b0;
        fifo_clr    = 1'b0;
        req_valid   = 1'b0;
        req_is_list = 1'b0;
        req_addr    = '0;
        req_len     = '0;

        if (stat_rd_en) s_d.done = '0;

        case (s_q.state)
            ST_IDLE: begin
                if (reg_wr_en) begin
                    case (reg_wr_addr)
                        RA_XFER_LEN: s_d.xfer_len = reg_wr_data;
                        RA_OFF_LAST: s_d.last_flag = reg_wr_data[0];
                        RA_LIST_LO:  s_d.list_addr[31:0] = reg_wr_data;
                        RA_LIST_HI:  s_d.list_addr[63:32] = reg_wr_data;
                        RA_LIST_LEN: begin
                            s_d.list_len = reg_wr_data;
                            if (reg_wr_data != '0 && s_q.xfer_len != '0) begin
                                s_d.state     = ST_LIST_REQ;
                                s_d.list_cnt  = '0;
                                s_d.rx_cnt    = '0;
                                s_d.req_total = '0;
                                s_d.cur_valid = 1'b0;
                                fifo_clr      = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_LIST_REQ: begin
                req_valid   = 1'b1;
                req_is_list = 1'b1;
                req_addr    = s_q.list_addr;
                req_len     = s_q.list_len;
                if (req_ready) s_d.state = ST_LIST_RX;
            end
            ST_LIST_RX: begin
                if (cpl_valid) begin
                    case (s_q.list_cnt[1:0])
                        2'd0: s_d.asm_addr[31:0]  = cpl_data;
                        2'd1: s_d.asm_addr[63:32] = cpl_data;
                        2'd2: s_d.asm_len         = cpl_data;
                        default: fifo_push        = 1'b1;
                    endcase
                    s_d.list_cnt = s_q.list_cnt + 1'b1;
                    if (s_q.list_cnt + 1'b1 == s_q.list_len) s_d.state = ST_DATA;
                end
            end
            default: begin
                if (s_q.cur_valid && more) begin
                    req_valid = 1'b1;
                    req_addr  = s_q.cur_addr;
                    req_len   = chunk;
                    if (req_ready) begin
                        s_d.cur_addr  = s_q.cur_addr + {chunk[29:0], 2'b00};
                        s_d.cur_rem   = s_q.cur_rem - chunk;
                        s_d.req_total = s_q.req_total + chunk;
                        s_d.cur_valid = (s_q.cur_rem != chunk);
                    end
                end else if (!s_q.cur_valid && more && !fifo_empty) begin
                    fifo_pop      = 1'b1;
                    s_d.cur_addr  = fifo_dout.addr;
                    s_d.cur_rem   = fifo_dout.len;
                    s_d.cur_valid = (fifo_dout.len != '0);
                end
                if (cpl_valid) begin
                    s_d.out_valid = 1'b1;
                    s_d.out_data  = cpl_data;
                    s_d.rx_cnt    = s_q.rx_cnt + 1'b1;
                    if (s_q.rx_cnt + 1'b1 == s_q.xfer_len) begin
                        s_d.out_last      = s_q.last_flag;
                        s_d.done[CHAN_ID] = 1'b1;
                        s_d.state         = ST_IDLE;
                        s_d.cur_valid     = 1'b0;
                        fifo_clr          = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid    = s_q.out_valid;
    assign out_data     = s_q.out_data;
    assign out_last     = s_q.out_last;
    assign stat_rd_data = s_q.done;
    assign irq          = |s_q.done;
endmodule

// File: rtl/sg_rx_channel_chk.sv
`timescale 1ns/1ps
module sg_rx_channel_chk #(
    parameter int unsigned MAX_REQ_WORDS = 32,
    parameter int unsigned PAGE_BYTES    = 4096
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_is_list,
    input logic [63:0] req_addr,
    input logic [31:0] req_len,
    input logic        out_valid,
    input logic        stat_rd_en,
    input logic        irq
);
    localparam int unsigned PG_W = $clog2(PAGE_BYTES);

    p_req_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_list) |-> (req_len != '0 && req_len <= 32'(MAX_REQ_WORDS)));

    p_no_page_cross_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_list) |->
            ((64'(req_addr[PG_W-1:0]) + 64'(req_len) * 64'd4) <= 64'(PAGE_BYTES)));

    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=>
            (req_valid && $stable(req_addr) && $stable(req_len) && $stable(req_is_list)));

    p_irq_with_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> out_valid);

    p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_en |=> (!irq || out_valid));
endmodule

bind sg_rx_channel sg_rx_channel_chk #(
    .MAX_REQ_WORDS (MAX_REQ_WORDS),
    .PAGE_BYTES    (PAGE_BYTES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_is_list (req_is_list),
    .req_addr    (req_addr),
    .req_len     (req_len),
    .out_valid   (out_valid),
    .stat_rd_en  (stat_rd_en),
    .irq         (irq)
);

// File: tb/sg_rx_channel_bench.sv
`timescale 1ns/1ps
module sg_rx_channel_bench;
    localparam int NUM_CH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              reg_wr_en = 1'b0;
    logic [2:0]        reg_wr_addr = '0;
    logic [31:0]       reg_wr_data = '0;
    logic              stat_rd_en = 1'b0;
    logic [NUM_CH-1:0] stat_rd_data;
    logic              req_valid, req_is_list;
    logic              req_ready;
    logic [63:0]       req_addr;
    logic [31:0]       req_len;
    logic              cpl_valid;
    logic [31:0]       cpl_data;
    logic              out_valid, out_last, irq;
    logic [31:0]       out_data;

    sg_rx_channel #(.NUM_CH(NUM_CH)) u_sg_rx_channel (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .stat_rd_en(stat_rd_en), .stat_rd_data(stat_rd_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_is_list(req_is_list),
        .req_addr(req_addr), .req_len(req_len),
        .cpl_valid(cpl_valid), .cpl_data(cpl_data),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    int rdy_mode = 0;
    logic [7:0]  lfsr;
    logic [31:0] cplq[$];
    logic [31:0] list_mem [0:15];

    logic [63:0] lg_addr [0:63];
    logic [31:0] lg_len  [0:63];
    logic        lg_list [0:63];
    int          lg_n;
    logic [63:0] ex_addr [0:63];
    logic [31:0] ex_len  [0:63];
    logic        ex_list [0:63];
    int          ex_n;

    logic [31:0] ob_data [0:255];
    logic        ob_last [0:255];
    int          ob_n;
    logic [31:0] eo_data [0:255];
    int          eo_n;
    int          irq_at;
    logic        irq_prev, hold_pend;
    logic [63:0] hold_addr;
    logic [31:0] hold_len;

    function automatic logic [31:0] dword(input logic [63:0] a);
        return a[31:0] ^ a[63:32] ^ 32'hA5A5_0000;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // host memory and completion model
    initial begin
        req_ready = 1'b0; cpl_valid = 1'b0; cpl_data = '0;
        lfsr = 8'h5B; irq_prev = 1'b0; hold_pend = 1'b0;
        hold_addr = '0; hold_len = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                req_ready = (rdy_mode == 0) ? 1'b1 : lfsr[0];
                if (out_valid && ob_n < 256) begin
                    ob_data[ob_n] = out_data;
                    ob_last[ob_n] = out_last;
                    ob_n++;
                end
                if (irq && !irq_prev) irq_at = ob_n;
                irq_prev = irq;
                if (hold_pend)
                    chk(req_valid && req_addr == hold_addr && req_len == hold_len,
                        "R12", "stalled request changed", req_addr, hold_addr);
                hold_pend = req_valid && !req_ready;
                hold_addr = req_addr;
                hold_len  = req_len;
                if (cplq.size() > 0 && (rdy_mode == 0 || lfsr[2])) begin
                    cpl_valid = 1'b1;
                    cpl_data  = cplq.pop_front();
                end else begin
                    cpl_valid = 1'b0;
                end
                if (req_valid && req_ready) begin
                    if (lg_n < 64) begin
                        lg_addr[lg_n] = req_addr;
                        lg_len[lg_n]  = req_len;
                        lg_list[lg_n] = req_is_list;
                        lg_n++;
                    end
                    for (int i = 0; i < int'(req_len) && i < 256; i++) begin
                        if (req_is_list) cplq.push_back(list_mem[i % 16]);
                        else             cplq.push_back(dword(req_addr + 64'(4 * i)));
                    end
                end
            end
        end
    end

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic clear_logs();
        lg_n = 0; ex_n = 0; ob_n = 0; eo_n = 0; irq_at = -1;
    endtask

    task automatic add_req(input logic [63:0] a, input logic [31:0] n, input logic lst);
        ex_addr[ex_n] = a; ex_len[ex_n] = n; ex_list[ex_n] = lst; ex_n++;
        if (!lst) for (int i = 0; i < int'(n); i++) begin
            eo_data[eo_n] = dword(a + 64'(4 * i));
            eo_n++;
        end
    endtask

    task automatic wait_done();
        int t;
        t = 0;
        while (!irq && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(irq, "R9", "interrupt raised", 64'(irq), 64'd1);
        repeat (20) @(negedge clk);
    endtask

    task automatic compare(input string rq_req, input logic last_exp);
        int bad;
        chk(lg_n == ex_n, rq_req, "request count", 64'(lg_n), 64'(ex_n));
        for (int i = 0; i < ex_n && i < lg_n; i++) begin
            chk(lg_addr[i] == ex_addr[i] && lg_len[i] == ex_len[i] && lg_list[i] == ex_list[i],
                rq_req, "request address/length", lg_addr[i], ex_addr[i]);
        end
        chk(ob_n == eo_n, "R7", "output word count", 64'(ob_n), 64'(eo_n));
        bad = -1;
        for (int i = 0; i < eo_n && i < ob_n; i++)
            if (bad < 0 && ob_data[i] != eo_data[i]) bad = i;
        chk(bad < 0, "R6", "output word order/data", 64'(bad), 64'hFFFF_FFFF_FFFF_FFFF);
        bad = -1;
        for (int i = 0; i < ob_n; i++)
            if (bad < 0 && ob_last[i] != (last_exp && i == eo_n - 1)) bad = i;
        chk(bad < 0, "R8", "out_last placement", 64'(bad), 64'hFFFF_FFFF_FFFF_FFFF);
        chk(irq_at == eo_n, "R9", "irq with final word", 64'(irq_at), 64'(eo_n));
    endtask

    task automatic read_status(input logic [NUM_CH-1:0] exp);
        logic [NUM_CH-1:0] v;
        @(negedge clk);
        stat_rd_en = 1'b1;
        v = stat_rd_data;
        @(negedge clk);
        stat_rd_en = 1'b0;
        chk(v == exp, "R9", "status bit for channel", 64'(v), 64'(exp));
        chk(!irq && stat_rd_data == '0, "R10", "read clears status", 64'(stat_rd_data), 64'd0);
    endtask

    task automatic t_reset();
        chk(!req_valid && !out_valid && !irq && stat_rd_data == '0, "R1",
            "idle after reset", {req_valid, out_valid, irq}, 64'd0);
    endtask

    task automatic t_single_element();
        clear_logs();
        rdy_mode = 0;
        list_mem[0] = 32'hFEED_0000; list_mem[1] = 32'h0;
        list_mem[2] = 32'd128;       list_mem[3] = 32'h0;
        add_req(64'h0000_0000_BEEF_0000, 32'd4, 1'b1);   // R1
        for (int k = 0; k < 4; k++)                        // R3 R5
            add_req(64'h0000_0000_FEED_0000 + 64'(128 * k), 32'd32, 1'b0);
        reg_wr(3'd0, 32'd128);
        reg_wr(3'd1, 32'd1);
        reg_wr(3'd2, 32'hBEEF_0000);
        reg_wr(3'd3, 32'h0);
        reg_wr(3'd4, 32'd4);
        wait_done();
        compare("R1", 1'b1);
        read_status(4'b0001);
    endtask

    task automatic t_page_and_empty();
        clear_logs();
        rdy_mode = 1;
        // R2: high address word is second; R5: zero-length element skipped
        list_mem[0] = 32'h0000_1FC0; list_mem[1] = 32'h0000_0001;
        list_mem[2] = 32'd40;        list_mem[3] = 32'h0;
        list_mem[4] = 32'h0000_3000; list_mem[5] = 32'h0;
        list_mem[6] = 32'd0;         list_mem[7] = 32'h0;
        list_mem[8] = 32'h0000_8000; list_mem[9] = 32'h0;
        list_mem[10] = 32'd5;        list_mem[11] = 32'h0;
        add_req(64'h0000_0002_0000_0100, 32'd12, 1'b1);
        add_req(64'h0000_0001_0000_1FC0, 32'd16, 1'b0);   // R4 edge split
        add_req(64'h0000_0001_0000_2000, 32'd24, 1'b0);
        add_req(64'h0000_0000_0000_8000, 32'd5, 1'b0);
        reg_wr(3'd0, 32'd45);
        reg_wr(3'd1, 32'd0);
        reg_wr(3'd2, 32'h0000_0100);
        reg_wr(3'd3, 32'h0000_0002);
        reg_wr(3'd4, 32'd12);
        wait_done();
        compare("R4", 1'b0);
        read_status(4'b0001);
    endtask

    task automatic t_early_end_and_busy();
        clear_logs();
        rdy_mode = 0;
        list_mem[0] = 32'h0000_4000; list_mem[1] = 32'h0;
        list_mem[2] = 32'd50;        list_mem[3] = 32'h0;
        list_mem[4] = 32'h0000_9000; list_mem[5] = 32'h0;
        list_mem[6] = 32'd8;         list_mem[7] = 32'h0;
        add_req(64'h0000_0000_0000_0200, 32'd8, 1'b1);
        add_req(64'h0000_0000_0000_4000, 32'd10, 1'b0);   // R7 capped by length
        reg_wr(3'd0, 32'd10);
        reg_wr(3'd1, 32'd1);
        reg_wr(3'd2, 32'h0000_0200);
        reg_wr(3'd3, 32'h0);
        reg_wr(3'd4, 32'd8);
        reg_wr(3'd0, 32'd3);      // R11: ignored while busy
        reg_wr(3'd4, 32'd4);
        wait_done();
        compare("R7", 1'b1);
        read_status(4'b0001);
        // R11: restart relies on the held length of 10
        clear_logs();
        add_req(64'h0000_0000_0000_0200, 32'd8, 1'b1);
        add_req(64'h0000_0000_0000_4000, 32'd10, 1'b0);
        reg_wr(3'd4, 32'd8);
        wait_done();
        compare("R11", 1'b1);
        read_status(4'b0001);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        clear_logs();
        @(negedge clk);
        t_reset();
        t_single_element();
        t_page_and_empty();
        t_early_end_and_busy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R9 run did not finish actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule